// File: doc/BRIEF.md
# Masked Read-Modify-Write Logic Unit

This block runs one display-memory access as a fixed sequence of four clock periods. It drives the word address, reads the word, combines it with a pattern and a mask, and writes the result back to the same address. The combine step is one of four bitwise operations: replace, complement, set or clear. It acts only on the bit positions that the mask enables. Within those positions, the pattern decides where complement, set and clear take effect.

The unit has two pattern modes. Character mode applies the full pattern word in parallel. Graphics mode takes one pattern bit per access and replicates it across the word. That mode suits pixel-at-a-time drawing, where a one-hot mask selects the pixel and successive accesses step through the pattern. A controller pulses a start strobe with the operands. The unit latches them and runs the access on its own. It flags the write phase with a one-cycle done pulse.

Top module: `rmw_logic_unit`

## Requirements
- R1: After an accepted start, the unit runs four phases, one clock each: address (busy high, no read or write strobe), read (`mem_rd_o` high), modify (no strobe), write (`mem_we_o` high). It then returns to idle with busy low.
- R2: The address, pattern, mask, operation and mode are latched on the accepting edge. `mem_addr_o` holds the latched address through all four phases, and later changes on the inputs have no effect on that access.
- R3: Every bit whose latched mask bit is 0 is written back with the value read in the read phase.
- R4: Operation code 00 (replace): each enabled bit takes the modify-data bit.
- R5: Operation code 01 (complement): each enabled bit whose modify-data bit is 1 is inverted. The other bits are kept.
- R6: Operation code 11 (set): each enabled bit whose modify-data bit is 1 is forced to 1. The other bits are kept.
- R7: Operation code 10 (clear): each enabled bit whose modify-data bit is 1 is forced to 0. The other bits are kept.
- R8: With `mode_i` = 0 (graphics), the modify data is pattern bit number `idx`, copied to every bit position.
- R9: With `mode_i` = 1 (character), the modify data is the whole 16-bit pattern word.
- R10: `idx` is 0 after reset. It grows by one after each completed graphics access, wraps from 15 to 0, and is left unchanged by character accesses.
- R11: A start strobe that arrives while the unit is busy is ignored. The running access keeps its phases and operands.
- R12: `done_o` is high for exactly the one clock of the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start an access (taken only when idle) |
| mode_i | input | 1 | 0 = graphics (serial pattern bit), 1 = character (parallel pattern) |
| op_i | input | 2 | 00 replace, 01 complement, 10 clear, 11 set |
| pattern_i | input | 16 | Pattern word |
| mask_i | input | 16 | Modify-enable mask |
| addr_i | input | 12 | Word address of the access |
| rdata_i | input | 16 | Memory read data, sampled at the end of the read phase |
| mem_addr_o | output | 12 | Address driven to memory for the whole access |
| mem_rd_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| wdata_o | output | 16 | Data to write back |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Write-phase pulse |

## Verification
A wrong phase register shows up within one clock as a strobe out of order or a busy level that does not match the phase. A corrupted operand latch or read-data capture appears at the next write phase as a wrong `wdata_o`: masked-off bits that differ from the read word, or enabled bits with the wrong function applied. A pattern index that drifts stays hidden until graphics accesses use a pattern with mixed bits. It then appears within one access, and over a run of more than sixteen graphics accesses any wrap fault becomes visible as well.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_REPLACE = 2'b00,
    OP_COMPL   = 2'b01,
    OP_CLEAR   = 2'b10,
    OP_SET     = 2'b11
  } rmw_op_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_READ  = 3'd2,
    PH_MOD   = 3'd3,
    PH_WRITE = 3'd4
  } rmw_phase_e;
endpackage

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output rmw_phase_e phase_o,
  output logic       accept_o
);
  rmw_phase_e phase_q, phase_d;

  assign accept_o = start_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_ADDR;
      PH_ADDR:  phase_d = PH_READ;
      PH_READ:  phase_d = PH_MOD;
      PH_MOD:   phase_d = PH_WRITE;
      PH_WRITE: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/rmw_pat_sel.sv
module rmw_pat_sel #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          char_mode_i,
  input  logic [DW-1:0] pattern_i,
  input  logic          advance_i,
  output logic [DW-1:0] md_o
);
  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (advance_i) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  logic ser_bit;
  assign ser_bit = pattern_i[idx_q];

  for (genvar g = 0; g < DW; g++) begin : g_md
    assign md_o[g] = char_mode_i ? pattern_i[g] : ser_bit;
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  rmw_op_e       op_i,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] md_i,
  output logic [DW-1:0] wd_o
);
  logic [DW-1:0] en;
  assign en = md_i & mask_i;

  always_comb begin
    unique case (op_i)
      OP_REPLACE: wd_o = (rd_i & ~mask_i) | en;
      OP_COMPL:   wd_o = rd_i ^ en;
      OP_CLEAR:   wd_o = rd_i & ~en;
      OP_SET:     wd_o = rd_i | en;
      default:    wd_o = rd_i;
    endcase
  end
endmodule

// File: rtl/rmw_logic_unit.sv
module rmw_logic_unit
  import rmw_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] pattern_i,
  input  logic [DW-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_we_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          done_o
);
  rmw_phase_e    phase;
  logic          accept;
  rmw_op_e       op_q;
  logic          mode_q;
  logic [DW-1:0] pat_q, mask_q, rd_q, wd_q, md, wd;
  logic [AW-1:0] addr_q;

  rmw_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .phase_o  (phase),
    .accept_o (accept)
  );

  // operand capture on the accepting edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_REPLACE;
      mode_q <= 1'b0;
      pat_q  <= '0;
      mask_q <= '0;
      addr_q <= '0;
    end else if (accept) begin
      op_q   <= rmw_op_e'(op_i);
      mode_q <= mode_i;
      pat_q  <= pattern_i;
      mask_q <= mask_i;
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wd_q <= '0;
    end else begin
      if (phase == PH_READ) rd_q <= rdata_i;
      if (phase == PH_MOD)  wd_q <= wd;
    end
  end

  rmw_pat_sel #(.DW(DW)) u_pat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .char_mode_i (mode_q),
    .pattern_i   (pat_q),
    .advance_i   ((phase == PH_WRITE) && !mode_q),
    .md_o        (md)
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op_i   (op_q),
    .rd_i   (rd_q),
    .mask_i (mask_q),
    .md_i   (md),
    .wd_o   (wd)
  );

  assign mem_addr_o = addr_q;
  assign mem_rd_o   = (phase == PH_READ);
  assign mem_we_o   = (phase == PH_WRITE);
  assign done_o     = (phase == PH_WRITE);
  assign busy_o     = (phase != PH_IDLE);
  assign wdata_o    = wd_q;
endmodule

// File: rtl/rmw_logic_unit_chk.sv
module rmw_logic_unit_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [DW-1:0] mask_i,
  input logic [DW-1:0] rdata_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_we_o,
  input logic [DW-1:0] wdata_o,
  input logic          busy_o,
  input logic          done_o
);
  logic [DW-1:0] rd_seen, mask_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_seen   <= '0;
      mask_seen <= '0;
    end else begin
      if (mem_rd_o)            rd_seen   <= rdata_i;
      if (start_i && !busy_o)  mask_seen <= mask_i;
    end
  end

  a_r1_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (!mem_rd_o && !mem_we_o) ##1 mem_we_o);
  a_r1_write_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !busy_o);
  a_r1_strobes_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_we_o}));
  a_r1_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !mem_rd_o && !mem_we_o));
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
  a_r3_masked_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (((wdata_o ^ rd_seen) & ~mask_seen) == '0));
  a_r12_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_done_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !mem_rd_o));
endmodule

bind rmw_logic_unit rmw_logic_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mask_i     (mask_i),
  .rdata_i    (rdata_i),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_we_o   (mem_we_o),
  .wdata_o    (wdata_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_rmw_logic_unit.sv
`timescale 1ns/1ps
module tb_rmw_logic_unit;
  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [DW-1:0] pattern_i = '0, mask_i = '0, rdata_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_we_o, busy_o, done_o;
  logic [DW-1:0] wdata_o;

  int checks = 0;
  int fails = 0;
  int idx_model = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rmw_logic_unit #(.DW(DW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .op_i(op_i), .pattern_i(pattern_i), .mask_i(mask_i), .addr_i(addr_i),
    .rdata_i(rdata_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_we_o(mem_we_o), .wdata_o(wdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_wd(input bit mode, input logic [1:0] op,
      input logic [DW-1:0] pat, input logic [DW-1:0] msk, input logic [DW-1:0] rd,
      input int idx);
    logic [DW-1:0] md, en;
    md = mode ? pat : (pat[idx] ? {DW{1'b1}} : {DW{1'b0}});
    en = md & msk;
    case (op)
      2'b00:   return (rd & ~msk) | en;
      2'b01:   return rd ^ en;
      2'b10:   return rd & ~en;
      default: return rd | en;
    endcase
  endfunction

  task automatic run_op(input bit mode, input logic [1:0] op, input logic [DW-1:0] pat,
                        input logic [DW-1:0] msk, input logic [DW-1:0] rd,
                        input logic [AW-1:0] a);
    logic [DW-1:0] exp;
    string tag;
    exp = expect_wd(mode, op, pat, msk, rd, idx_model);
    case (op)
      2'b00:   tag = mode ? "R4/R9/R3" : "R4/R8/R10/R3";
      2'b01:   tag = mode ? "R5/R9/R3" : "R5/R8/R10/R3";
      2'b10:   tag = mode ? "R7/R9/R3" : "R7/R8/R10/R3";
      default: tag = mode ? "R6/R9/R3" : "R6/R8/R10/R3";
    endcase
    @(negedge clk);
    mode_i = mode; op_i = op; pattern_i = pat; mask_i = msk; addr_i = a; start_i = 1'b1;
    rdata_i = ~rd;
    @(negedge clk); // address phase
    check(busy_o && !mem_rd_o && !mem_we_o && !done_o, "R1 addr phase",
          {busy_o, mem_rd_o, mem_we_o, done_o}, 4'b1000);
    check(mem_addr_o == a, "R2 addr", mem_addr_o, a);
    // R11: a second start while busy, with scrambled operands, must be ignored
    mode_i = ~mode; op_i = op ^ 2'b01; pattern_i = ~pat; mask_i = ~msk;
    addr_i = ~a; start_i = 1'b1; rdata_i = rd;
    @(negedge clk); // read phase
    start_i = 1'b0;
    check(mem_rd_o && !mem_we_o && busy_o, "R1/R11 read phase",
          {busy_o, mem_rd_o, mem_we_o}, 3'b110);
    check(mem_addr_o == a, "R2/R11 addr", mem_addr_o, a);
    @(negedge clk); // modify phase
    rdata_i = ~rd;
    check(!mem_rd_o && !mem_we_o && busy_o && !done_o, "R1/R12 modify phase",
          {busy_o, mem_rd_o, mem_we_o, done_o}, 4'b1000);
    @(negedge clk); // write phase
    check(mem_we_o && !mem_rd_o && done_o, "R1/R12 write phase",
          {mem_we_o, mem_rd_o, done_o}, 3'b101);
    check(mem_addr_o == a, "R2 write addr", mem_addr_o, a);
    check(wdata_o == exp, tag, wdata_o, exp);
    @(negedge clk); // idle
    check(!busy_o && !done_o && !mem_we_o, "R1/R12 idle after write",
          {busy_o, done_o, mem_we_o}, 3'b000);
    if (!mode) idx_model = (idx_model + 1) % DW;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=complete");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !mem_rd_o && !mem_we_o && !done_o && wdata_o == '0, "R1 reset state",
          {busy_o, mem_rd_o, mem_we_o, done_o}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o, "R1 idle without start", busy_o, 1'b0);

    // R10: graphics index from 0 with a one-hot pattern marks each step
    run_op(1'b0, 2'b11, 16'h0001, 16'hFFFF, 16'h0000, 12'h001);
    run_op(1'b0, 2'b11, 16'h0001, 16'hFFFF, 16'h0000, 12'h002);

    // sweep modes, operations and data patterns
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 4; o++) begin
        for (int k = 0; k < 8; k++) begin
          logic [DW-1:0] pat, msk, rd;
          pat = 16'hA5C3 ^ (16'h1357 * k[15:0]) ^ (16'h0F0F << o);
          case (k)
            0:       msk = 16'hFFFF;
            1:       msk = 16'h0000;
            2:       msk = 16'h0001 << (o * 3 + m);
            default: msk = 16'h6DB6 ^ (16'h2468 * k[15:0]);
          endcase
          rd = 16'h3C5A ^ (16'h0F1E * k[15:0]) ^ {8'h00, o[3:0], m[3:0]};
          run_op(m[0], o[1:0], pat, msk, rd, AW'(k * 37 + o * 5 + m));
        end
      end
    end

    // R10: character access between graphics accesses leaves the index alone,
    // then a long graphics run crosses the wrap from 15 to 0
    run_op(1'b1, 2'b00, 16'hBEEF, 16'hFFFF, 16'h0000, 12'hABC);
    for (int n = 0; n < 20; n++)
      run_op(1'b0, 2'b00, 16'h8421 ^ 16'(n), 16'hFFFF, 16'h5555, AW'(n));
    for (int n = 0; n < 18; n++)
      run_op(1'b0, 2'b01, 16'hC003, 16'h0F0F, 16'h00FF, AW'(n + 100));

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule